// File: doc/BRIEF.md
# Header-Based Frame Aligner

This block finds frame alignment in the parallel word stream that a serial transceiver delivers. A free-running phase counter marks one cycle in every `WORD_RATIO` cycles as a frame boundary. On that cycle only, the block compares a small group of header bits from the current word with a constant pattern. While it is hunting, a wrong header makes it pulse a bitslip request to the transceiver. It then holds off for a fixed settle time before it checks headers again.

The lock decision uses hysteresis. A run of `REQ_TRUE` consecutive good headers declares lock. Once locked, the block counts checks in windows of `OVER_N`. Up to `ALLOW_FALSE` bad headers per window are tolerated, and one more drops the lock. After that the hunt resumes without an immediate slip. The block also reports whether it has issued an even number of bitslips. A separate synchronous input restarts the search without disturbing the frame-phase counter.

The header input is a plain stream sampled every cycle. It has no valid or ready: a transceiver word cannot be held back, so the block applies no back-pressure and never stalls the word source. All other pins are plain control and status levels.

Top module: `frame_aligner`

## Requirements
- R1: `hdr_flag_o` is high for exactly one cycle in every `WORD_RATIO` cycles. It is high throughout datapath reset and in the first cycle after reset is released.
- R2: Headers are judged only on cycles where `hdr_flag_o` is high. Header values on any other cycle never cause a slip or a loss of lock.
- R3: While unlocked and checking, a mismatching header at a boundary raises `slip_o` in the next cycle. It stays high for exactly `SLIP_MIN` cycles, and `slip_o` is never high while `locked_o` is high.
- R4: After `slip_o` falls, at least `SLIP_WAIT` cycles pass before headers are judged again. The next slip therefore rises between `SLIP_WAIT+1` and `SLIP_WAIT+WORD_RATIO` cycles after the fall.
- R5: `locked_o` rises in the cycle after the `REQ_TRUE`-th consecutive matching boundary. A mismatch while hunting restarts the run from zero.
- R6: While locked, up to `ALLOW_FALSE` mismatching checks within one window of `OVER_N` checks keep `locked_o` high.
- R7: The check that brings a window's mismatch count above `ALLOW_FALSE` drops `locked_o` in the next cycle. The block then hunts again without issuing a slip first.
- R8: At the end of every window of `OVER_N` checks, both the check count and the mismatch count restart from zero, so mismatches in neighbouring windows do not add up.
- R9: `slip_even_o` is 1 when the number of slips issued since the last reset of either kind is even. It toggles in the same cycle that `slip_o` rises.
- R10: A high `search_rst` at a clock edge returns the search to hunting with `locked_o`=0, `slip_o`=0 and `slip_even_o`=1. The `hdr_flag_o` cadence is unaffected.
- R11: During datapath reset (`rst_n`=0), `locked_o`=0, `slip_o`=0 and `slip_even_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transceiver word clock |
| rst_n | input | 1 | Asynchronous active-low datapath reset |
| search_rst | input | 1 | Synchronous restart of the alignment search only |
| hdr_i | input | HDR_W | Header bits taken from the current word |
| hdr_flag_o | output | 1 | Frame-boundary strobe, one cycle per frame |
| slip_o | output | 1 | Bitslip request to the transceiver |
| locked_o | output | 1 | Frame alignment achieved |
| slip_even_o | output | 1 | Number of slips issued is even |

## Verification
The bench builds the block with `WORD_RATIO`=4, `REQ_TRUE`=3, `ALLOW_FALSE`=1, `OVER_N`=4, `SLIP_MIN`=2, `SLIP_WAIT`=5 and pattern `2'b10`. With these values a full hunt takes a few dozen cycles, and a two-cycle slip pulse makes the pulse width observable. The window is short enough that the bench can place bad headers on exact check indices: one inside a window, a pair straddling a window edge, and a pair inside one window. A transceiver model turns each slip into a shift, so the good alignment is reached after a chosen number of slips. That exercises both parities of the slip count and a restart of the search in mid-lock.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    FA_HUNT   = 2'd0,
    FA_SLIP   = 2'd1,
    FA_SETTLE = 2'd2,
    FA_LOCK   = 2'd3
  } fa_state_e;
endpackage

// File: rtl/fa_phase_ctr.sv
module fa_phase_ctr #(
  parameter int WORD_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_edge_o
);
  localparam int PW = (WORD_RATIO > 1) ? $clog2(WORD_RATIO) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(WORD_RATIO - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                     ph_q <= ph_q + 1'b1;
  end

  assign frame_edge_o = (ph_q == '0);
endmodule

// File: rtl/fa_hdr_match.sv
module fa_hdr_match #(
  parameter int              HDR_W   = 2,
  parameter logic [HDR_W-1:0] HDR_PAT = 2'b01
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic             match_o
);
  assign match_o = (hdr_i == HDR_PAT);
endmodule

// File: rtl/fa_search_fsm.sv
module fa_search_fsm
  import fa_pkg::*;
#(
  parameter int REQ_TRUE    = 32,
  parameter int ALLOW_FALSE = 4,
  parameter int OVER_N      = 64,
  parameter int SLIP_MIN    = 1,
  parameter int SLIP_WAIT   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic search_rst,
  input  logic frame_edge,
  input  logic match,
  output logic slip_o,
  output logic locked_o,
  output logic slip_even_o
);
  localparam int TW   = (REQ_TRUE > 1) ? $clog2(REQ_TRUE) : 1;
  localparam int CW   = (OVER_N > 1) ? $clog2(OVER_N) : 1;
  localparam int FW   = (ALLOW_FALSE > 0) ? $clog2(ALLOW_FALSE + 1) : 1;
  localparam int DMAX = (SLIP_MIN > SLIP_WAIT) ? SLIP_MIN : SLIP_WAIT;
  localparam int DW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  localparam logic [TW-1:0] TRUE_LAST   = TW'(REQ_TRUE - 1);
  localparam logic [CW-1:0] CHK_LAST    = CW'(OVER_N - 1);
  localparam logic [FW-1:0] FALSE_LIMIT = FW'(ALLOW_FALSE);
  localparam logic [DW-1:0] SLIP_LAST   = DW'(SLIP_MIN - 1);
  localparam logic [DW-1:0] WAIT_LAST   = DW'(SLIP_WAIT - 1);

  fa_state_e     st_q, st_d;
  logic [TW-1:0] true_q, true_d;
  logic [CW-1:0] chk_q, chk_d;
  logic [FW-1:0] false_q, false_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          par_q, par_d;

  always_comb begin
    st_d    = st_q;
    true_d  = true_q;
    chk_d   = chk_q;
    false_d = false_q;
    dly_d   = dly_q;
    par_d   = par_q;
    unique case (st_q)
      FA_HUNT: begin
        if (frame_edge) begin
          if (match) begin
            if (true_q == TRUE_LAST) begin
              st_d    = FA_LOCK;
              true_d  = '0;
              chk_d   = '0;
              false_d = '0;
            end else begin
              true_d = true_q + 1'b1;
            end
          end else begin
            true_d = '0;
            dly_d  = '0;
            par_d  = ~par_q;
            st_d   = FA_SLIP;
          end
        end
      end
      FA_SLIP: begin
        if (dly_q == SLIP_LAST) begin
          dly_d = '0;
          st_d  = FA_SETTLE;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      FA_SETTLE: begin
        if (dly_q == WAIT_LAST) begin
          dly_d = '0;
          st_d  = FA_HUNT;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      FA_LOCK: begin
        if (frame_edge) begin
          if (!match && (false_q == FALSE_LIMIT)) begin
            st_d   = FA_HUNT;
            true_d = '0;
          end else if (chk_q == CHK_LAST) begin
            chk_d   = '0;
            false_d = '0;
          end else begin
            chk_d = chk_q + 1'b1;
            if (!match) false_d = false_q + 1'b1;
          end
        end
      end
      default: st_d = FA_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FA_HUNT;
      true_q  <= '0;
      chk_q   <= '0;
      false_q <= '0;
      dly_q   <= '0;
      par_q   <= 1'b0;
    end else if (search_rst) begin
      st_q    <= FA_HUNT;
      true_q  <= '0;
      chk_q   <= '0;
      false_q <= '0;
      dly_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      true_q  <= true_d;
      chk_q   <= chk_d;
      false_q <= false_d;
      dly_q   <= dly_d;
      par_q   <= par_d;
    end
  end

  assign slip_o      = (st_q == FA_SLIP);
  assign locked_o    = (st_q == FA_LOCK);
  assign slip_even_o = ~par_q;
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int               HDR_W       = 2,
  parameter logic [HDR_W-1:0] HDR_PAT     = 2'b01,
  parameter int               WORD_RATIO  = 8,
  parameter int               REQ_TRUE    = 32,
  parameter int               ALLOW_FALSE = 4,
  parameter int               OVER_N      = 64,
  parameter int               SLIP_MIN    = 1,
  parameter int               SLIP_WAIT   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_rst,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             hdr_flag_o,
  output logic             slip_o,
  output logic             locked_o,
  output logic             slip_even_o
);
  logic frame_edge;
  logic match;

  fa_phase_ctr #(.WORD_RATIO(WORD_RATIO)) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_edge_o (frame_edge)
  );

  fa_hdr_match #(.HDR_W(HDR_W), .HDR_PAT(HDR_PAT)) u_match (
    .hdr_i   (hdr_i),
    .match_o (match)
  );

  fa_search_fsm #(
    .REQ_TRUE    (REQ_TRUE),
    .ALLOW_FALSE (ALLOW_FALSE),
    .OVER_N      (OVER_N),
    .SLIP_MIN    (SLIP_MIN),
    .SLIP_WAIT   (SLIP_WAIT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .search_rst  (search_rst),
    .frame_edge  (frame_edge),
    .match       (match),
    .slip_o      (slip_o),
    .locked_o    (locked_o),
    .slip_even_o (slip_even_o)
  );

  assign hdr_flag_o = frame_edge;
endmodule

// File: rtl/fa_aligner_chk.sv
module fa_aligner_chk #(
  parameter int WORD_RATIO = 8,
  parameter int SLIP_MIN   = 1
) (
  input logic clk,
  input logic rst_n,
  input logic search_rst,
  input logic hdr_flag_o,
  input logic slip_o,
  input logic locked_o,
  input logic slip_even_o
);
  int   slip_run_q;
  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_run_q <= 0;
      gap_q      <= 0;
      seen_q     <= 1'b0;
    end else begin
      if (search_rst || !slip_o) slip_run_q <= 0;
      else                       slip_run_q <= slip_run_q + 1;
      if (hdr_flag_o) begin
        gap_q  <= 0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1;
      end
    end
  end

  // R1: boundary strobe spacing
  p_flag_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_flag_o && seen_q) |-> (gap_q == WORD_RATIO - 1));

  // R2: slips and lock changes start only from a boundary decision
  p_slip_from_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slip_o) |-> $past(hdr_flag_o));

  p_lock_from_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(hdr_flag_o));

  p_unlock_from_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked_o) && !$past(search_rst)) |-> $past(hdr_flag_o));

  // R3: pulse width and exclusivity with lock
  p_slip_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(slip_o) && !$past(search_rst)) |-> (slip_run_q == SLIP_MIN));

  p_slip_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip_run_q <= SLIP_MIN);

  p_slip_not_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |-> !locked_o);

  // R9: parity follows slip starts only
  p_parity_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slip_o) |-> (slip_even_o != $past(slip_even_o)));

  p_parity_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(slip_o) && !$past(search_rst)) |-> $stable(slip_even_o));
endmodule

bind frame_aligner fa_aligner_chk #(
  .WORD_RATIO (WORD_RATIO),
  .SLIP_MIN   (SLIP_MIN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .search_rst  (search_rst),
  .hdr_flag_o  (hdr_flag_o),
  .slip_o      (slip_o),
  .locked_o    (locked_o),
  .slip_even_o (slip_even_o)
);

// File: tb/tb_frame_aligner.sv
module tb_frame_aligner;
  localparam int         CLK_PERIOD = 10;
  localparam int         HW  = 2;
  localparam logic [1:0] PAT = 2'b10;
  localparam int         WR  = 4;
  localparam int         REQ = 3;
  localparam int         AF  = 1;
  localparam int         NW  = 4;
  localparam int         SM  = 2;
  localparam int         SW  = 5;

  typedef struct { int width; bit even; } slip_exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          search_rst = 1'b0;
  logic [HW-1:0] hdr_i = ~PAT;
  logic          hdr_flag_o, slip_o, locked_o, slip_even_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  slip_exp_t exp_q[$];

  // transceiver and monitor state
  int    slips = 0;
  int    target = 3;
  int    run = 0;
  int    fall_cyc = 0;
  bit    have_fall = 0;
  bit    lock_armed = 0;
  int    last_flag = -1;
  int    lk_idx = 0;
  int    unlock_idx = -1;
  bit    nonbnd_bad = 0;
  logic [31:0] bad_mask = '0;
  logic  prev_slip = 0;
  logic  prev_lock = 0;

  frame_aligner #(
    .HDR_W(HW), .HDR_PAT(PAT), .WORD_RATIO(WR), .REQ_TRUE(REQ),
    .ALLOW_FALSE(AF), .OVER_N(NW), .SLIP_MIN(SM), .SLIP_WAIT(SW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .search_rst(search_rst), .hdr_i(hdr_i),
    .hdr_flag_o(hdr_flag_o), .slip_o(slip_o), .locked_o(locked_o),
    .slip_even_o(slip_even_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor (scoreboard pop side) and transceiver model, all at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_flag_o) begin
        if (last_flag >= 0) check("R1", cyc - last_flag, WR, "strobe period");
        last_flag = cyc;
      end
      if (slip_o && !prev_slip) begin
        slips++;
        run = 1;
        if (have_fall) begin
          checks++;
          if ((cyc - fall_cyc) < SW + 1 || (cyc - fall_cyc) > SW + WR) begin
            fails++;
            $display("FAIL R4 slip gap: actual %0d expected %0d..%0d",
                     cyc - fall_cyc, SW + 1, SW + WR);
          end
        end
      end else if (slip_o) begin
        run++;
      end
      if (!slip_o && prev_slip) begin
        if (exp_q.size() == 0) begin
          check("R3", 1, 0, "unexpected slip pulse");
        end else begin
          slip_exp_t e;
          e = exp_q.pop_front();
          check("R3", run, e.width, "slip width");
          check("R9", int'(slip_even_o), int'(e.even), "parity after slip");
        end
        fall_cyc   = cyc;
        have_fall  = 1;
        lock_armed = 1;
      end
      if (locked_o && !prev_lock) begin
        lk_idx = 0;
        if (lock_armed) begin
          checks++;
          if ((cyc - fall_cyc) < SW + 1 + (REQ - 1) * WR || (cyc - fall_cyc) > SW + REQ * WR) begin
            fails++;
            $display("FAIL R5 lock latency: actual %0d expected %0d..%0d",
                     cyc - fall_cyc, SW + 1 + (REQ - 1) * WR, SW + REQ * WR);
          end
        end
        lock_armed = 0;
      end
      if (!locked_o && prev_lock) unlock_idx = lk_idx;
      // drive the next header
      begin
        bit bad;
        bad = ((slips % 4) != target);
        if (locked_o && hdr_flag_o) begin
          if (lk_idx < 32 && bad_mask[lk_idx]) bad = 1;
          lk_idx++;
        end
        if (locked_o && !hdr_flag_o && nonbnd_bad) bad = 1;
        hdr_i = bad ? ~PAT : PAT;
      end
    end
    prev_slip = slip_o;
    prev_lock = locked_o;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  task automatic wait_lock(input bit level, input string req);
    int n = 0;
    while (locked_o !== level && n < 2000) begin
      @(negedge clk);
      #1;
      n++;
    end
    check(req, int'(locked_o), int'(level), "lock level reached");
  endtask

  task automatic push_slip(input bit even);
    slip_exp_t e;
    e.width = SM;
    e.even  = even;
    exp_q.push_back(e);
  endtask

  initial begin
    // R11: reset values
    repeat (3) @(negedge clk);
    #1;
    check("R11", int'(locked_o), 0, "locked in reset");
    check("R11", int'(slip_o), 0, "slip in reset");
    check("R11", int'(slip_even_o), 1, "even in reset");
    check("R1", int'(hdr_flag_o), 1, "strobe in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(hdr_flag_o), 1, "strobe after release");

    // Phase 1: three slips reach alignment, parity odd
    push_slip(1'b0);
    push_slip(1'b1);
    push_slip(1'b0);
    nonbnd_bad = 1;               // R2: junk between boundaries once locked
    bad_mask   = 32'h0000_6182;   // checks 1; 7,8 straddle; 13,14 same window
    wait_lock(1'b1, "R5");
    check("R3", slips, 3, "slips before lock");
    check("R9", int'(slip_even_o), 0, "odd slip count");

    // R6/R8/R2: survive single and straddling mismatches
    while (lk_idx < 13 && locked_o) @(negedge clk);
    #1;
    check("R6", int'(locked_o), 1, "lock held through tolerated mismatches");
    check("R8", lk_idx, 13, "reached window 3 while locked");
    nonbnd_bad = 0;

    // R7: second mismatch in one window drops lock
    wait_lock(1'b0, "R7");
    bad_mask = '0;
    check("R7", unlock_idx, 15, "unlock index");
    wait_lock(1'b1, "R7");
    check("R7", slips, 3, "relock without slip");

    // R10: restart the search; new alignment needs two slips
    @(negedge clk);
    search_rst = 1'b1;
    target = 2;
    @(posedge clk);
    #1;
    slips = 0;
    have_fall = 0;
    lock_armed = 0;
    push_slip(1'b0);
    push_slip(1'b1);
    @(negedge clk);
    search_rst = 1'b0;
    #1;
    check("R10", int'(locked_o), 0, "locked after restart");
    check("R10", int'(slip_o), 0, "slip after restart");
    check("R10", int'(slip_even_o), 1, "even after restart");
    wait_lock(1'b1, "R5");
    check("R9", slips, 2, "slips after restart");
    check("R9", int'(slip_even_o), 1, "even slip count");
    repeat (3 * WR) @(negedge clk);
    check("R3", exp_q.size(), 0, "pending expected slips");

    done = 1;
    finish_run();
  end
endmodule